// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block serves host accesses to a network controller's data port. Each access moves 1, 2 or 4 bytes between the port and the controller's local memory. The remote start address supplied by the register file acts as a running pointer. The remote byte count acts as the remaining length. The block returns the advanced pointer and the reduced count to the register file. When the count runs out, it raises a one-cycle completion pulse.

The local memory has two disjoint windows:

- a small address ROM area that holds the station address, and
- a packet RAM window placed higher in the address space.

Writes that fall outside both windows are dropped. Reads outside them return all ones. A read strobe on the reset port returns zero, signals a device reset and restores the ROM area.

Register decoding and the receive path live outside this block. The pointer, the count, the ring start and stop pages and the station address arrive as inputs.

Top module: `remote_dma_port`

## Requirements
- R1: Bytes at addresses 0 to PROM_BYTES-1 (default 32) and RAM_BASE to RAM_BASE+RAM_BYTES-1 (defaults 16384 and 2048) are storage. A byte written anywhere else is dropped, and a later read of it returns 0xFF.
- R2: A read of an address outside both windows returns all ones at the access width: 0xFF, 0xFFFF or 0xFFFFFFFF in the low bits of `rd_data`, with the unused upper bits of `rd_data` zero.
- R3: `acc_size` encodes the access width: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. For 2- and 4-byte accesses the pointer LSB is treated as 0. Data is little-endian: the byte at the lowest address is in `rd_data[7:0]` and `acc_wdata[7:0]`. Each byte lane is checked against the windows on its own.
- R4: After an accepted access, `ptr_o` is the input pointer (before its LSB is forced) plus the access width. If that sum equals `ring_stop` times 256, `ptr_o` becomes `ring_start` times 256.
- R5: After an accepted access, if the input count is less than or equal to the width, `cnt_o` is 0 and `done_o` pulses. Otherwise `cnt_o` is the count minus the width and `done_o` stays low.
- R6: A write strobed while `dma_cnt` is 0 is ignored. Memory keeps its contents, and `upd_o` and `done_o` stay low.
- R7: After reset, ROM bytes 0 to 5 hold `mac_addr`, with `mac_addr[47:40]` at byte 0. Bytes 14 and 15 hold 0x57, and every other ROM byte holds 0xFF.
- R8: A `rst_port_rd` strobe wins over any data access. One cycle later `rd_valid` is 1, `rd_data` is 0 and `dev_rst_o` pulses, and the ROM area is back to its R7 contents.
- R9: All results appear on the clock edge after the strobe. `upd_o` pulses for every accepted access, and `rd_valid` pulses for every accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Data port access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | Access width code (see R3) |
| acc_wdata | input | 32 | Write data, little-endian |
| dma_ptr | input | AW | Current remote address |
| dma_cnt | input | CW | Remaining byte count |
| ring_start | input | 8 | First page of the ring |
| ring_stop | input | 8 | Page after the ring end |
| mac_addr | input | 48 | Station address loaded into the ROM area |
| rst_port_rd | input | 1 | Read strobe on the reset port |
| rd_data | output | 32 | Read result |
| rd_valid | output | 1 | Read result valid |
| ptr_o | output | AW | Advanced pointer |
| cnt_o | output | CW | Reduced count |
| upd_o | output | 1 | Pointer and count update pulse |
| done_o | output | 1 | Transfer complete pulse |
| dev_rst_o | output | 1 | Device reset pulse |

## Verification
The bench first fills the packet RAM with a long streaming run of word writes. The pointer of this run passes the stop page, which exercises the ring wrap. Random accesses then draw their pointers from four pools:

- the ROM area,
- the RAM interior,
- a few bytes around the RAM end, where some byte lanes fall out of the window,
- the whole address space.

Sizes are mixed, and small or zero counts are common, so the saturating count and the completion pulse are separated from plain decrements. Directed cases cover:

- odd pointers with wide accesses, which tell forced alignment apart from the untouched pointer advance,
- writes with a zero count, which tell an ignored access apart from a dropped out-of-window one,
- a ROM overwrite followed by a reset-port read, which shows the restore.

// File: rtl/remote_dma_port.sv
module remote_dma_port #(
  parameter int AW         = 16,
  parameter int CW         = 16,
  parameter int PROM_BYTES = 32,
  parameter int RAM_BASE   = 16384,
  parameter int RAM_BYTES  = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [1:0]    acc_size,
  input  logic [31:0]   acc_wdata,
  input  logic [AW-1:0] dma_ptr,
  input  logic [CW-1:0] dma_cnt,
  input  logic [7:0]    ring_start,
  input  logic [7:0]    ring_stop,
  input  logic [47:0]   mac_addr,
  input  logic          rst_port_rd,
  output logic [31:0]   rd_data,
  output logic          rd_valid,
  output logic [AW-1:0] ptr_o,
  output logic [CW-1:0] cnt_o,
  output logic          upd_o,
  output logic          done_o,
  output logic          dev_rst_o
);
  localparam int LW  = AW + 1;
  localparam int RIW = $clog2(RAM_BYTES);
  localparam int PIW = $clog2(PROM_BYTES);

  logic [7:0] ram  [RAM_BYTES];
  logic [7:0] prom [PROM_BYTES];

  logic [2:0]     nbytes;
  logic [AW-1:0]  base, step, ptr_nx;
  logic [LW-1:0]  la   [4];
  logic           on   [4];
  logic           in_p [4];
  logic           in_r [4];
  logic [RIW-1:0] ridx [4];
  logic [PIW-1:0] pidx [4];
  logic [31:0]    rd_word;
  logic           go, wr_go, rd_go, last;

  function automatic logic [7:0] prom_init(int k, logic [47:0] mac);
    if (k < 6) return mac[47-8*k -: 8];
    if (k == 14 || k == 15) return 8'h57;
    return 8'hFF;
  endfunction

  assign nbytes = (acc_size == 2'd0) ? 3'd1 : (acc_size == 2'd1) ? 3'd2 : 3'd4;
  assign base   = (acc_size == 2'd0) ? dma_ptr : {dma_ptr[AW-1:1], 1'b0};
  assign step   = dma_ptr + AW'(nbytes);
  assign ptr_nx = (step == AW'({ring_stop, 8'h00})) ? AW'({ring_start, 8'h00}) : step;
  assign last   = dma_cnt <= CW'(nbytes);
  assign go     = acc_valid && !rst_port_rd && (!acc_write || dma_cnt != '0);
  assign wr_go  = go && acc_write;
  assign rd_go  = go && !acc_write;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      la[i]   = {1'b0, base} + LW'(i);
      on[i]   = 3'(i) < nbytes;
      in_p[i] = la[i] < LW'(PROM_BYTES);
      in_r[i] = la[i] >= LW'(RAM_BASE) && la[i] < LW'(RAM_BASE + RAM_BYTES);
      ridx[i] = RIW'(la[i] - LW'(RAM_BASE));
      pidx[i] = PIW'(la[i]);
      if (!on[i])       rd_word[8*i +: 8] = 8'h00;
      else if (in_p[i]) rd_word[8*i +: 8] = prom[pidx[i]];
      else if (in_r[i]) rd_word[8*i +: 8] = ram[ridx[i]];
      else              rd_word[8*i +: 8] = 8'hFF;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go)
      for (int i = 0; i < 4; i++)
        if (on[i] && in_r[i]) ram[ridx[i]] <= acc_wdata[8*i +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < PROM_BYTES; k++) prom[k] <= prom_init(k, mac_addr);
    end else if (rst_port_rd) begin
      for (int k = 0; k < PROM_BYTES; k++) prom[k] <= prom_init(k, mac_addr);
    end else if (wr_go) begin
      for (int i = 0; i < 4; i++)
        if (on[i] && in_p[i]) prom[pidx[i]] <= acc_wdata[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      ptr_o     <= '0;
      cnt_o     <= '0;
      upd_o     <= 1'b0;
      done_o    <= 1'b0;
      dev_rst_o <= 1'b0;
    end else begin
      rd_valid  <= rd_go || rst_port_rd;
      upd_o     <= go;
      done_o    <= go && last;
      dev_rst_o <= rst_port_rd;
      if (rst_port_rd) rd_data <= '0;
      else if (rd_go)  rd_data <= rd_word;
      if (go) begin
        ptr_o <= ptr_nx;
        cnt_o <= last ? '0 : dma_cnt - CW'(nbytes);
      end
    end
  end
endmodule

// File: rtl/remote_dma_port_chk.sv
module remote_dma_port_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_write,
  input logic [1:0]    acc_size,
  input logic [CW-1:0] dma_cnt,
  input logic          rst_port_rd,
  input logic [31:0]   rd_data,
  input logic          rd_valid,
  input logic [CW-1:0] cnt_o,
  input logic          upd_o,
  input logic          done_o,
  input logic          dev_rst_o
);
  p_done_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cnt_o == '0) && upd_o);

  p_count_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !rst_port_rd && !acc_write && dma_cnt > 16'd4) |=> (cnt_o < $past(dma_cnt)) && !done_o);

  p_zero_cnt_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && dma_cnt == '0) |=> !upd_o && !done_o);

  p_reset_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_port_rd |=> rd_valid && dev_rst_o && (rd_data == 32'h0) && !upd_o);

  p_byte_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_size == 2'd0 && !rst_port_rd) |=> rd_valid && (rd_data[31:8] == 24'h0));

  p_read_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && !rst_port_rd) |=> rd_valid && upd_o);
endmodule

bind remote_dma_port remote_dma_port_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_size(acc_size), .dma_cnt(dma_cnt), .rst_port_rd(rst_port_rd),
  .rd_data(rd_data), .rd_valid(rd_valid), .cnt_o(cnt_o), .upd_o(upd_o),
  .done_o(done_o), .dev_rst_o(dev_rst_o)
);

// File: tb/remote_dma_port_test.sv
`timescale 1ns/1ps
module remote_dma_port_test;
  localparam int PB = 32, RB = 16384, RN = 2048;
  localparam logic [47:0] MAC = 48'h02_1A_2B_3C_4D_5E;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0, rst_port_rd = 0;
  logic [1:0] acc_size = 0;
  logic [31:0] acc_wdata = 0;
  logic [15:0] dma_ptr = 0, dma_cnt = 0;
  logic [7:0] ring_start = 8'h40, ring_stop = 8'h48;
  logic [31:0] rd_data;
  logic rd_valid, upd_o, done_o, dev_rst_o;
  logic [15:0] ptr_o, cnt_o;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] m_prom [PB];
  logic [7:0] m_ram [RN];
  int ptr_m = 0, cnt_m = 0;

  always #4 clk = ~clk;

  remote_dma_port #(.PROM_BYTES(PB), .RAM_BASE(RB), .RAM_BYTES(RN)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_size(acc_size), .acc_wdata(acc_wdata), .dma_ptr(dma_ptr), .dma_cnt(dma_cnt),
    .ring_start(ring_start), .ring_stop(ring_stop), .mac_addr(MAC),
    .rst_port_rd(rst_port_rd), .rd_data(rd_data), .rd_valid(rd_valid),
    .ptr_o(ptr_o), .cnt_o(cnt_o), .upd_o(upd_o), .done_o(done_o), .dev_rst_o(dev_rst_o));

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rom_default(int k);
    if (k < 6) return MAC[47-8*k -: 8];
    if (k == 14 || k == 15) return 8'h57;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] m_read(int a);
    if (a < PB) return m_prom[a];
    if (a >= RB && a < RB + RN) return m_ram[a-RB];
    return 8'hFF;
  endfunction

  task automatic access(bit wr, logic [1:0] sz, logic [31:0] wd, string rq);
    int nb, base, nxt;
    bit go, fin;
    logic [31:0] exp;
    nb   = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    base = (sz == 0) ? ptr_m : (ptr_m & 16'hFFFE);
    go   = !wr || cnt_m != 0;
    exp  = 0;
    for (int i = 0; i < nb; i++) begin
      int a = base + i;
      exp[8*i +: 8] = m_read(a);
      if (wr && go) begin
        if (a < PB) m_prom[a] = wd[8*i +: 8];
        else if (a >= RB && a < RB + RN) m_ram[a-RB] = wd[8*i +: 8];
      end
    end
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_size = sz; acc_wdata = wd;
    dma_ptr = 16'(ptr_m); dma_cnt = 16'(cnt_m);
    @(negedge clk);
    acc_valid = 0;
    chk(upd_o == go, "R9", "update pulse", 32'(upd_o), 32'(go));
    if (!wr) begin
      chk(rd_valid == 1'b1, "R9", "read valid", 32'(rd_valid), 32'h1);
      chk(rd_data == exp, rq, "read data", rd_data, exp);
    end
    if (go) begin
      nxt = (ptr_m + nb) & 16'hFFFF;
      if (nxt == ring_stop * 256) nxt = ring_start * 256;
      fin = cnt_m <= nb;
      chk(ptr_o == 16'(nxt), "R4", "pointer", 32'(ptr_o), 32'(nxt));
      chk(done_o == fin, "R5", "done pulse", 32'(done_o), 32'(fin));
      cnt_m = fin ? 0 : cnt_m - nb;
      chk(cnt_o == 16'(cnt_m), "R5", "count", 32'(cnt_o), 32'(cnt_m));
      ptr_m = nxt;
    end else begin
      chk(done_o == 1'b0, "R6", "done on ignored write", 32'(done_o), 32'h0);
    end
  endtask

  task automatic rd_at(int p, logic [1:0] sz, string rq);
    ptr_m = p; cnt_m = 16'h100;
    access(0, sz, 0, rq);
  endtask

  task automatic wr_at(int p, logic [1:0] sz, logic [31:0] d, int c, string rq);
    ptr_m = p; cnt_m = c;
    access(1, sz, d, rq);
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < PB; k++) m_prom[k] = rom_default(k);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(upd_o == 0 && rd_valid == 0 && done_o == 0 && dev_rst_o == 0, "R9", "reset outputs",
        {upd_o, rd_valid, done_o, dev_rst_o}, 32'h0);

    // R7: ROM contents after reset
    rd_at(0, 2'd2, "R7"); rd_at(4, 2'd1, "R7"); rd_at(12, 2'd2, "R7"); rd_at(31, 2'd0, "R7");

    // R4: fill the RAM by streaming, wrapping past the stop page
    ptr_m = RB; cnt_m = 16'hFFFF;
    for (int w = 0; w < RN / 4; w++) access(1, 2'd2, $urandom, "R1");
    chk(ptr_m == RB, "R4", "stream wrapped", 32'(ptr_m), RB);

    // R2: reads outside both windows
    rd_at(16'h2000, 2'd0, "R2"); rd_at(16'h2001, 2'd1, "R2");
    rd_at(16'hC000, 2'd2, "R2"); rd_at(40, 2'd3, "R2");

    // R1: writes outside dropped; window edge lanes
    wr_at(16'h3FFE, 2'd2, 32'hA1B2C3D4, 8, "R1");
    rd_at(16'h3FFE, 2'd2, "R1");
    wr_at(RB + RN - 2, 2'd2, 32'h11223344, 8, "R1");
    rd_at(RB + RN - 2, 2'd2, "R1");
    rd_at(30, 2'd2, "R1");

    // R3: odd pointer with wide access
    wr_at(RB + 101, 2'd2, 32'hDEADBEEF, 9, "R3");
    rd_at(RB + 100, 2'd0, "R3"); rd_at(RB + 103, 2'd0, "R3"); rd_at(RB + 101, 2'd1, "R3");

    // R4: wrap from word and dword accesses
    rd_at(16'h47FE, 2'd1, "R4"); rd_at(16'h47FC, 2'd2, "R4"); rd_at(16'h47FD, 2'd2, "R4");

    // R5: saturation corners
    ptr_m = RB; cnt_m = 4; access(0, 2'd2, 0, "R5");
    ptr_m = RB; cnt_m = 5; access(0, 2'd2, 0, "R5");
    ptr_m = RB; cnt_m = 1; access(0, 2'd1, 0, "R5");
    ptr_m = RB; cnt_m = 0; access(0, 2'd0, 0, "R5");

    // R6: write with zero count leaves memory alone
    wr_at(RB + 200, 2'd2, 32'h55AA55AA, 0, "R6");
    rd_at(RB + 200, 2'd2, "R6");
    wr_at(3, 2'd0, 32'h00000099, 0, "R6");
    rd_at(0, 2'd2, "R6");

    // R8: reset port restores ROM
    wr_at(3, 2'd0, 32'h00000099, 2, "R8");
    rd_at(0, 2'd2, "R8");
    @(negedge clk);
    rst_port_rd = 1; acc_valid = 1; acc_write = 1; dma_cnt = 16'd9;
    @(negedge clk);
    rst_port_rd = 0; acc_valid = 0;
    chk(rd_valid == 1 && rd_data == 0, "R8", "reset port read", rd_data, 32'h0);
    chk(dev_rst_o == 1 && upd_o == 0, "R8", "reset pulse", {dev_rst_o, upd_o}, 32'h2);
    for (int k = 0; k < PB; k++) m_prom[k] = rom_default(k);
    rd_at(0, 2'd2, "R8"); rd_at(12, 2'd2, "R8");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int pool = $urandom % 5;
      bit wr = $urandom % 2;
      logic [1:0] sz = 2'($urandom % 4);
      case (pool)
        0: ptr_m = $urandom % PB;
        1: ptr_m = RB + ($urandom % RN);
        2: ptr_m = RB + RN - 4 + ($urandom % 8);
        3: ptr_m = $urandom % 65536;
        default: ;
      endcase
      cnt_m = ($urandom % 6 == 0) ? 0 : ($urandom % 12);
      access(wr, sz, $urandom, "R3");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule